// File: doc/BRIEF.md
# Lane Arithmetic Unit with Signed Three-Way Compare

This block is the arithmetic unit of one thread lane in a small SIMD core. Each lane carries its own copy. The unit takes two 8-bit register operands, here called the source and target values, and a 4-bit operation code. It performs add, subtract, multiply or unsigned divide, and it can also run a signed compare. The compare yields a one-hot negative/zero/positive code that the core's branch logic consumes later.

All outputs are registered, so a result appears on the rising edge after its inputs are presented. The lane's active bit drives the enable input. While a lane is inactive, its unit keeps every output as it was. An arithmetic result is flagged valid only when the register file may store it. A divide by a zero divisor is therefore never flagged valid, and neither is any operation code outside the arithmetic set. The compare code has its own valid flag and is kept separately from the arithmetic result.

Top module: `lane_alu`

## Requirements
- R1: While `rst_n` is low, `result` is 0, `nzp` is 3'b000, and `result_valid` and `nzp_valid` are both 0. The reset acts without waiting for a clock edge.
- R2: With `en` high and opcode 4'b0011, the rising edge loads `result` with (rs_val + rt_val) mod 256 and sets `result_valid` to 1.
- R3: With `en` high and opcode 4'b0100, the rising edge loads `result` with (rs_val - rt_val) mod 256 and sets `result_valid` to 1.
- R4: With `en` high and opcode 4'b0101, the rising edge loads `result` with the low 8 bits of the unsigned product and sets `result_valid` to 1.
- R5: With `en` high, opcode 4'b0110 and a nonzero `rt_val`, the rising edge loads `result` with the unsigned integer quotient rs_val / rt_val, rounded down, and sets `result_valid` to 1.
- R6: With `en` high, opcode 4'b0110 and `rt_val` equal to 0, the rising edge clears `result_valid` and leaves `result` unchanged.
- R7: With `en` high and opcode 4'b0010, the rising edge loads `nzp` from the sign of the true signed difference rs_val - rt_val. Both operands are read as two's complement, and the difference is not wrapped. The code is {N,Z,P}: 3'b100 for negative, 3'b010 for zero and 3'b001 for positive. The same edge sets `nzp_valid` to 1, clears `result_valid` and leaves `result` unchanged.
- R8: With `en` high and any opcode other than 0010 to 0110, the rising edge clears both `result_valid` and `nzp_valid` and leaves `result` and `nzp` unchanged.
- R9: With `en` low, the rising edge leaves all four outputs unchanged, the valid flags included, whatever the opcode and operands are.
- R10: `nzp` changes only on a compare. Arithmetic operations leave it unchanged. It is always either all zero or one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Lane active bit; outputs update only when high |
| opcode | input | 4 | Operation code |
| rs_val | input | 8 | Source operand |
| rt_val | input | 8 | Target operand (second operand, divisor) |
| result | output | 8 | Registered arithmetic result |
| result_valid | output | 1 | High when the last enabled operation produced a storable result |
| nzp | output | 3 | Registered compare code {N,Z,P} |
| nzp_valid | output | 1 | High when the last enabled operation was a compare |

## Verification
Every output is due on the first rising edge after the stimulus is applied, one register stage later. The only exception is reset, which clears the outputs at once. The bench drives inputs on the falling edge and samples 2 ns after the next rising edge. Each check therefore sees the edge it expects and nothing later. Hold behaviour covers inactive lanes, zero divisors, compare-only updates and opcodes outside the set. The bench checks it by tracking the expected held values across consecutive operations and comparing at every following sample.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_CMP = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'b0011;
  localparam logic [OPC_W-1:0] OPC_SUB = 4'b0100;
  localparam logic [OPC_W-1:0] OPC_MUL = 4'b0101;
  localparam logic [OPC_W-1:0] OPC_DIV = 4'b0110;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_ADD,
    CLS_SUB,
    CLS_MUL,
    CLS_DIV,
    CLS_CMP
  } op_class_e;

  // one-hot {N,Z,P}
  localparam logic [2:0] NZP_NEG  = 3'b100;
  localparam logic [2:0] NZP_ZERO = 3'b010;
  localparam logic [2:0] NZP_POS  = 3'b001;

endpackage

// File: rtl/lane_alu_decode.sv
module lane_alu_decode
  import lane_alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output op_class_e        op_class
);

  always_comb begin
    case (opcode)
      OPC_ADD: op_class = CLS_ADD;
      OPC_SUB: op_class = CLS_SUB;
      OPC_MUL: op_class = CLS_MUL;
      OPC_DIV: op_class = CLS_DIV;
      OPC_CMP: op_class = CLS_CMP;
      default: op_class = CLS_NONE;
    endcase
  end

endmodule

// File: rtl/lane_alu_datapath.sv
module lane_alu_datapath
  import lane_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_class_e         op_class,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] arith_value,
  output logic              arith_ok,
  output logic              div_zero,
  output logic              cmp_hit,
  output logic [2:0]        cmp_code
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int DIFF_W = DATA_W + 1;

  function automatic logic [DATA_W-1:0] f_add(input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [DATA_W-1:0] f_sub(input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] y);
    return x - y;
  endfunction

  function automatic logic [DATA_W-1:0] f_mul_lo(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    logic [PROD_W-1:0] full;
    full = {{DATA_W{1'b0}}, x} * {{DATA_W{1'b0}}, y};
    return full[DATA_W-1:0];
  endfunction

  // quotient; a zero divisor returns zero so no X leaks, the caller gates it
  function automatic logic [DATA_W-1:0] f_div(input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] y);
    if (y == '0) return '0;
    return x / y;
  endfunction

  // sign of the unwrapped two's complement difference
  function automatic logic [2:0] f_cmp(input logic [DATA_W-1:0] x,
                                       input logic [DATA_W-1:0] y);
    logic signed [DIFF_W-1:0] sx;
    logic signed [DIFF_W-1:0] sy;
    logic signed [DIFF_W-1:0] d;
    sx = $signed({x[DATA_W-1], x});
    sy = $signed({y[DATA_W-1], y});
    d  = sx - sy;
    if (d < 0)       return NZP_NEG;
    else if (d == 0) return NZP_ZERO;
    else             return NZP_POS;
  endfunction

  always_comb begin
    div_zero = (op_class == CLS_DIV) && (src_b == '0);
    cmp_hit  = (op_class == CLS_CMP);
    cmp_code = f_cmp(src_a, src_b);
    case (op_class)
      CLS_ADD: begin arith_value = f_add(src_a, src_b);    arith_ok = 1'b1;      end
      CLS_SUB: begin arith_value = f_sub(src_a, src_b);    arith_ok = 1'b1;      end
      CLS_MUL: begin arith_value = f_mul_lo(src_a, src_b); arith_ok = 1'b1;      end
      CLS_DIV: begin arith_value = f_div(src_a, src_b);    arith_ok = !div_zero; end
      default: begin arith_value = '0;                     arith_ok = 1'b0;      end
    endcase
  end

endmodule

// File: rtl/lane_alu_outreg.sv
module lane_alu_outreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load_res,
  input  logic [DATA_W-1:0] res_in,
  input  logic              load_nzp,
  input  logic [2:0]        nzp_in,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic [2:0]        nzp,
  output logic              nzp_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result       <= '0;
      result_valid <= 1'b0;
      nzp          <= 3'b000;
      nzp_valid    <= 1'b0;
    end else if (en) begin
      if (load_res) result <= res_in;
      if (load_nzp) nzp    <= nzp_in;
      result_valid <= load_res;
      nzp_valid    <= load_nzp;
    end
  end

endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [3:0]        opcode,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic [2:0]        nzp,
  output logic              nzp_valid
);

  // named internal events, observed by the bound checker
  op_class_e         op_class_w;
  logic [DATA_W-1:0] arith_value_w;
  logic              arith_ok_w;
  logic              div_zero_w;
  logic              cmp_hit_w;
  logic [2:0]        cmp_code_w;

  lane_alu_decode decode_i (
    .opcode   (opcode),
    .op_class (op_class_w)
  );

  lane_alu_datapath #(.DATA_W(DATA_W)) datapath_i (
    .op_class    (op_class_w),
    .src_a       (rs_val),
    .src_b       (rt_val),
    .arith_value (arith_value_w),
    .arith_ok    (arith_ok_w),
    .div_zero    (div_zero_w),
    .cmp_hit     (cmp_hit_w),
    .cmp_code    (cmp_code_w)
  );

  lane_alu_outreg #(.DATA_W(DATA_W)) outreg_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .load_res     (arith_ok_w),
    .res_in       (arith_value_w),
    .load_nzp     (cmp_hit_w),
    .nzp_in       (cmp_code_w),
    .result       (result),
    .result_valid (result_valid),
    .nzp          (nzp),
    .nzp_valid    (nzp_valid)
  );

endmodule

// File: rtl/lane_alu_chk.sv
module lane_alu_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [3:0]        opcode,
  input logic [DATA_W-1:0] rs_val,
  input logic [DATA_W-1:0] rt_val,
  input logic [DATA_W-1:0] result,
  input logic              result_valid,
  input logic [2:0]        nzp,
  input logic              nzp_valid,
  input logic              div_zero_w,
  input logic              cmp_hit_w
);

  logic              armed;
  logic [DATA_W-1:0] sum_w;

  assign sum_w = rs_val + rt_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R10
  nzp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(nzp));

  // R7
  nzp_code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nzp_valid |-> $countones(nzp) == 1);

  // R8
  valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(result_valid && nzp_valid));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(en) |->
      $stable(result) && $stable(nzp) && $stable(result_valid) && $stable(nzp_valid));

  // R6
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(en && div_zero_w) |-> !result_valid && $stable(result));

  // R7
  cmp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(en && cmp_hit_w) |-> nzp_valid && !result_valid && $stable(result));

  // R2
  add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(en && opcode == 4'b0011) |-> result_valid && result == $past(sum_w));

  // R10
  nzp_arith_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(en && !cmp_hit_w) |-> $stable(nzp));

endmodule

bind lane_alu lane_alu_chk #(.DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en),
  .opcode       (opcode),
  .rs_val       (rs_val),
  .rt_val       (rt_val),
  .result       (result),
  .result_valid (result_valid),
  .nzp          (nzp),
  .nzp_valid    (nzp_valid),
  .div_zero_w   (div_zero_w),
  .cmp_hit_w    (cmp_hit_w)
);

// File: tb/lane_alu_tb_top.sv
`timescale 1ns/1ps
module lane_alu_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [3:0] opcode;
  logic [7:0] rs_val;
  logic [7:0] rt_val;
  logic [7:0] result;
  logic       result_valid;
  logic [2:0] nzp;
  logic       nzp_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  lane_alu dut_i (
    .clk (clk), .rst_n (rst_n), .en (en), .opcode (opcode),
    .rs_val (rs_val), .rt_val (rt_val), .result (result),
    .result_valid (result_valid), .nzp (nzp), .nzp_valid (nzp_valid)
  );

  // row: op[32:29] a[28:21] b[20:13] res[12:5] rv[4] nzp[3:1] nv[0]
  localparam int NV = 16;
  localparam logic [32:0] VEC [NV] = '{
    {4'h3, 8'h05, 8'h03, 8'h08, 1'b1, 3'b000, 1'b0},  // R2
    {4'h3, 8'hFF, 8'h02, 8'h01, 1'b1, 3'b000, 1'b0},  // R2 wrap
    {4'h4, 8'h10, 8'h01, 8'h0F, 1'b1, 3'b000, 1'b0},  // R3
    {4'h4, 8'h00, 8'h01, 8'hFF, 1'b1, 3'b000, 1'b0},  // R3 wrap
    {4'h5, 8'h07, 8'h09, 8'h3F, 1'b1, 3'b000, 1'b0},  // R4
    {4'h5, 8'h20, 8'h10, 8'h00, 1'b1, 3'b000, 1'b0},  // R4 truncation
    {4'h5, 8'h13, 8'h11, 8'h43, 1'b1, 3'b000, 1'b0},  // R4 truncation
    {4'h6, 8'hC8, 8'h07, 8'h1C, 1'b1, 3'b000, 1'b0},  // R5
    {4'h6, 8'h05, 8'h09, 8'h00, 1'b1, 3'b000, 1'b0},  // R5
    {4'h6, 8'hFF, 8'h01, 8'hFF, 1'b1, 3'b000, 1'b0},  // R5
    {4'h2, 8'h03, 8'h05, 8'h00, 1'b0, 3'b100, 1'b1},  // R7 neg
    {4'h2, 8'h05, 8'h05, 8'h00, 1'b0, 3'b010, 1'b1},  // R7 zero
    {4'h2, 8'h7F, 8'h80, 8'h00, 1'b0, 3'b001, 1'b1},  // R7 127-(-128)
    {4'h2, 8'h80, 8'h7F, 8'h00, 1'b0, 3'b100, 1'b1},  // R7 -128-127
    {4'h2, 8'hFF, 8'h01, 8'h00, 1'b0, 3'b100, 1'b1},  // R7 -1-1
    {4'h2, 8'h01, 8'hFF, 8'h00, 1'b0, 3'b001, 1'b1}   // R7 1-(-1)
  };

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h3: return "R2";
      4'h4: return "R3";
      4'h5: return "R4";
      4'h6: return "R5";
      4'h2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] e_res, input logic e_rv,
                       input logic [2:0] e_nzp, input logic e_nv);
    n_chk++;
    if (result !== e_res || result_valid !== e_rv || nzp !== e_nzp || nzp_valid !== e_nv) begin
      n_bad++;
      $display("FAIL %s: got res=%h rv=%b nzp=%b nv=%b, expected res=%h rv=%b nzp=%b nv=%b",
               req, result, result_valid, nzp, nzp_valid, e_res, e_rv, e_nzp, e_nv);
    end
  endtask

  task automatic step(input logic e, input logic [3:0] op, input logic [7:0] a,
                      input logic [7:0] b);
    @(negedge clk);
    en = e; opcode = op; rs_val = a; rt_val = b;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got running, expected finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_res;
    logic [2:0] exp_nzp;
    rst_n = 1'b0; en = 1'b0; opcode = 4'h0; rs_val = 8'h00; rt_val = 8'h00;
    repeat (3) @(posedge clk);
    #2;
    check("R1", 8'h00, 1'b0, 3'b000, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    exp_res = 8'h00;
    exp_nzp = 3'b000;
    for (int i = 0; i < NV; i++) begin
      step(1'b1, VEC[i][32:29], VEC[i][28:21], VEC[i][20:13]);
      if (VEC[i][4]) exp_res = VEC[i][12:5];
      if (VEC[i][0]) exp_nzp = VEC[i][3:1];
      check(tag_of(VEC[i][32:29]), exp_res, VEC[i][4], exp_nzp, VEC[i][0]);
    end
    // state now: res=FF nzp=001

    // R2 then R6: zero divisor keeps the result, flags not valid
    step(1'b1, 4'h3, 8'h21, 8'h01);
    check("R2", 8'h22, 1'b1, 3'b001, 1'b0);
    step(1'b1, 4'h6, 8'h40, 8'h00);
    check("R6", 8'h22, 1'b0, 3'b001, 1'b0);
    step(1'b1, 4'h3, 8'h01, 8'h01);
    check("R2", 8'h02, 1'b1, 3'b001, 1'b0);
    step(1'b1, 4'h6, 8'h00, 8'h00);
    check("R6", 8'h02, 1'b0, 3'b001, 1'b0);

    // R8: codes outside the arithmetic set
    step(1'b1, 4'h0, 8'h01, 8'h01);
    check("R8", 8'h02, 1'b0, 3'b001, 1'b0);
    step(1'b1, 4'h7, 8'h05, 8'h06);
    check("R8", 8'h02, 1'b0, 3'b001, 1'b0);
    step(1'b1, 4'h2, 8'h01, 8'h02);
    check("R7", 8'h02, 1'b0, 3'b100, 1'b1);
    step(1'b1, 4'hF, 8'h05, 8'h06);
    check("R8", 8'h02, 1'b0, 3'b100, 1'b0);
    step(1'b1, 4'h8, 8'h05, 8'h06);
    check("R8", 8'h02, 1'b0, 3'b100, 1'b0);

    // R9: inactive lane holds every output
    step(1'b1, 4'h3, 8'h03, 8'h04);
    check("R2", 8'h07, 1'b1, 3'b100, 1'b0);
    step(1'b0, 4'h3, 8'h09, 8'h09);
    check("R9", 8'h07, 1'b1, 3'b100, 1'b0);
    step(1'b0, 4'h2, 8'h09, 8'h01);
    check("R9", 8'h07, 1'b1, 3'b100, 1'b0);
    step(1'b1, 4'h2, 8'h09, 8'h01);
    check("R7", 8'h07, 1'b0, 3'b001, 1'b1);
    step(1'b0, 4'h5, 8'h02, 8'h02);
    check("R9", 8'h07, 1'b0, 3'b001, 1'b1);

    // R10: arithmetic leaves the compare code alone
    step(1'b1, 4'h2, 8'h02, 8'h09);
    check("R7", 8'h07, 1'b0, 3'b100, 1'b1);
    step(1'b1, 4'h4, 8'h0A, 8'h02);
    check("R10", 8'h08, 1'b1, 3'b100, 1'b0);
    step(1'b1, 4'h6, 8'h00, 8'h05);
    check("R5", 8'h00, 1'b1, 3'b100, 1'b0);

    // R1: reset in mid-run clears at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", 8'h00, 1'b0, 3'b000, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule